// File: doc/BRIEF.md
# Flat Page-Table Address Translator

This block turns 32-bit device virtual addresses into physical addresses. It uses a single-level page table in memory. Pages are always 4 KB. The table holds one 32-bit descriptor per page, so it spans the whole 4 GB space: 1M descriptors, 4 MB in total. A small fully associative TLB keeps descriptors that were fetched recently, so a repeated page costs no memory access.

A requester presents an address on a valid/ready handshake. On a TLB hit the result comes back one cycle after acceptance. On a miss, an internal walker issues one read request at `tbl_base + page_index*4` and waits for the descriptor.

- If the descriptor is valid, it is cached and used for the result.
- If it is invalid, the access is reported as a translation fault. The returned address then points at a protect buffer aligned to 128 bytes, so the faulting traffic has a harmless place to land.

Top module: `pgtab_xlate`

## Requirements
- R1: After reset, req_ready is 1, rsp_valid is 0 and mem_req_valid is 0.
- R2: A request that misses in the TLB issues one read at address tbl_base + va[31:12]*4. req_ready stays 0 from acceptance until the response is produced.
- R3: A descriptor with bit 1 set (valid) gives a response one cycle after mem_rsp_valid with the following fields. The response itself is a single-cycle rsp_valid pulse with no back-pressure.
  - rsp_pa = {desc[31:12], va[11:0]}
  - rsp_fault = 0
  - rsp_nonsec = desc[3]
- R4: A descriptor with bit 1 clear (this includes the all-zero unmapped entry) gives the following response:
  - rsp_fault = 1
  - rsp_nonsec = 0
  - rsp_pa = {prot_base[31:7], 7'b0}
- R5: A request whose page is in the TLB produces rsp_valid one cycle after acceptance, with no memory read.
- R6: A faulting descriptor is never cached. Repeating the access walks the table again.
- R7: The TLB holds TLB_N entries (default 8) and fills them in round-robin order from reset.
  - The fill that follows the TLB_N-th one replaces the first-filled entry.
  - The other entries keep hitting.
- R8: While a walk is outstanding:
  - mem_req_valid and mem_req_addr stay stable until mem_req_ready.
  - No second read is issued before the descriptor returns.
  - mem_rsp_valid outside a walk is ignored.
- R9: The page offset va[11:0] passes through unchanged. Descriptor bits other than [31:12], 3 and 1 do not affect the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tbl_base | input | 32 | Physical base address of the page table |
| prot_base | input | 32 | Protect buffer address (bits 6:0 ignored) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Translator can accept a request |
| req_va | input | 32 | Virtual address to translate |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_pa | output | 32 | Translated or redirected physical address |
| rsp_fault | output | 1 | Translation fault |
| rsp_nonsec | output | 1 | Non-secure flag from the descriptor |
| mem_req_valid | output | 1 | Walker read request valid |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 32 | Descriptor address |
| mem_rsp_valid | input | 1 | Descriptor data valid |
| mem_rsp_data | input | 32 | Descriptor returned by memory |

## Verification
The bench builds the translator with its defaults: TLB_N=8, PG_W=12 and PROT_W=7. With eight entries, nine distinct page fills are enough to wrap the round-robin pointer and observe the eviction of the oldest entry. The fixed 12-bit offset and 7-bit protect alignment let the expected addresses be formed directly from the descriptor model. The memory model can delay its grant, which shows the walker holding its request. It can also inject a stray descriptor beat between walks.

// File: rtl/pgtab_xlate.sv
module pgtab_xlate #(
  parameter int TLB_N  = 8,
  parameter int PG_W   = 12,
  parameter int PROT_W = 7
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] tbl_base,
  input  logic [31:0] prot_base,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [31:0] req_va,
  output logic        rsp_valid,
  output logic [31:0] rsp_pa,
  output logic        rsp_fault,
  output logic        rsp_nonsec,
  output logic        mem_req_valid,
  input  logic        mem_req_ready,
  output logic [31:0] mem_req_addr,
  input  logic        mem_rsp_valid,
  input  logic [31:0] mem_rsp_data
);
  localparam int VPN_W = 32 - PG_W;
  localparam int PTR_W = (TLB_N > 1) ? $clog2(TLB_N) : 1;
  localparam int D_VLD = 1;
  localparam int D_NS  = 3;

  typedef enum logic [1:0] {IDLE, ASK, WAIT} st_t;
  st_t state;

  logic [31:0]      va_q;
  logic [PTR_W-1:0] ptr;
  logic [TLB_N-1:0] t_v;
  logic [VPN_W-1:0] t_vpn [TLB_N];
  logic [VPN_W-1:0] t_ppn [TLB_N];
  logic [TLB_N-1:0] t_ns;

  logic [TLB_N-1:0] hit_vec;
  logic [VPN_W-1:0] hit_ppn;
  logic             hit_ns;
  logic             fill;
  logic             unused_bits;

  always_comb begin
    hit_vec = '0;
    hit_ppn = '0;
    hit_ns  = 1'b0;
    for (int i = 0; i < TLB_N; i++) begin
      hit_vec[i] = t_v[i] && (t_vpn[i] == req_va[31:PG_W]);
      if (hit_vec[i]) begin
        hit_ppn = hit_ppn | t_ppn[i];
        hit_ns  = hit_ns | t_ns[i];
      end
    end
  end

  assign req_ready     = (state == IDLE);
  assign mem_req_valid = (state == ASK);
  assign mem_req_addr  = tbl_base + 32'({va_q[31:PG_W], 2'b00});
  assign fill          = (state == WAIT) && mem_rsp_valid && mem_rsp_data[D_VLD];
  assign unused_bits   = ^{mem_rsp_data[PG_W-1:D_NS+1], mem_rsp_data[D_NS-1:D_VLD+1],
                           mem_rsp_data[0], prot_base[PROT_W-1:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= IDLE;
      va_q       <= '0;
      ptr        <= '0;
      t_v        <= '0;
      rsp_valid  <= 1'b0;
      rsp_pa     <= '0;
      rsp_fault  <= 1'b0;
      rsp_nonsec <= 1'b0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        IDLE: if (req_valid) begin
          va_q <= req_va;
          if (|hit_vec) begin
            rsp_valid  <= 1'b1;
            rsp_pa     <= {hit_ppn, req_va[PG_W-1:0]};
            rsp_fault  <= 1'b0;
            rsp_nonsec <= hit_ns;
          end else begin
            state <= ASK;
          end
        end
        ASK: if (mem_req_ready) state <= WAIT;
        WAIT: if (mem_rsp_valid) begin
          state     <= IDLE;
          rsp_valid <= 1'b1;
          if (mem_rsp_data[D_VLD]) begin
            rsp_pa     <= {mem_rsp_data[31:PG_W], va_q[PG_W-1:0]};
            rsp_fault  <= 1'b0;
            rsp_nonsec <= mem_rsp_data[D_NS];
            t_v[ptr]   <= 1'b1;
            ptr        <= (ptr == PTR_W'(TLB_N - 1)) ? '0 : ptr + 1'b1;
          end else begin
            rsp_pa     <= {prot_base[31:PROT_W], {PROT_W{1'b0}}};
            rsp_fault  <= 1'b1;
            rsp_nonsec <= 1'b0;
          end
        end
        default: state <= IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (fill) begin
      t_vpn[ptr] <= va_q[31:PG_W];
      t_ppn[ptr] <= mem_rsp_data[31:PG_W];
      t_ns[ptr]  <= mem_rsp_data[D_NS];
    end
  end

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid && !mem_req_ready |=> mem_req_valid && $stable(mem_req_addr));

  // R2
  stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !req_ready);

  // R5
  hit_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready && req_valid && (|hit_vec) |=> rsp_valid && !rsp_fault && !mem_req_valid);

  // R4
  fault_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_fault && rsp_valid |-> !rsp_nonsec);

  // R7
  unique_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(hit_vec));
endmodule

// File: tb/pgtab_xlate_test.sv
module pgtab_xlate_test;
  localparam int CLK_T = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [31:0] tbl_base = 32'h8000_0000;
  logic [31:0] prot_base = 32'h0040_12FF;
  logic req_valid = 1'b0, req_ready;
  logic [31:0] req_va = '0;
  logic rsp_valid, rsp_fault, rsp_nonsec;
  logic [31:0] rsp_pa;
  logic mem_req_valid, mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr;
  logic mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic model_v = 1'b0, stray_v = 1'b0;
  logic [31:0] model_d = '0;

  int checks = 0, fails = 0, walks = 0, drops = 0, gnt_delay = 0;
  logic [31:0] last_addr = '0;

  assign mem_rsp_valid = model_v | stray_v;
  assign mem_rsp_data  = stray_v ? 32'hDEAD_B00A : model_d;

  always #(CLK_T/2) clk = ~clk;

  pgtab_xlate uut (
    .clk(clk), .rst_n(rst_n), .tbl_base(tbl_base), .prot_base(prot_base),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .rsp_valid(rsp_valid), .rsp_pa(rsp_pa), .rsp_fault(rsp_fault), .rsp_nonsec(rsp_nonsec),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data));

  function automatic logic [31:0] desc_of(logic [19:0] v);
    if (v[19:16] == 4'hF) return 32'h0;
    if (v[19:16] == 4'hE) return {v ^ 20'h0F0F0, 12'hFF5};
    return {v ^ 20'h5A5A5, 8'hC3, v[0], 1'b0, 1'b1, 1'b0};
  endfunction

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    forever begin
      @(negedge clk);
      if (mem_req_valid) begin
        logic [31:0] a;
        a = mem_req_addr;
        for (int k = 0; k < gnt_delay; k++) begin
          @(negedge clk);
          if (!mem_req_valid || mem_req_addr != a) drops++;
        end
        mem_req_ready = 1'b1;
        last_addr = mem_req_addr;
        walks++;
        @(negedge clk);
        mem_req_ready = 1'b0;
        @(negedge clk);
        model_v = 1'b1;
        model_d = desc_of(20'((last_addr - tbl_base) >> 2));
        @(negedge clk);
        model_v = 1'b0;
      end
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic xl(logic [31:0] va, bit exp_walk, string tag);
    int w0, lat, stalls;
    logic [31:0] d, epa;
    w0 = walks; stalls = 0; lat = 0;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_va = va;
    @(negedge clk);
    req_valid = 1'b0;
    while (!rsp_valid && lat < 100) begin
      if (req_ready) stalls++;
      @(negedge clk);
      lat++;
    end
    d = desc_of(va[31:12]);
    epa = d[1] ? {d[31:12], va[11:0]} : {prot_base[31:7], 7'b0};
    chk(rsp_valid, {tag, " response seen"}, 32'(rsp_valid), 1);
    chk(rsp_pa == epa, {tag, " pa"}, rsp_pa, epa);
    chk(rsp_fault == !d[1], {tag, " fault"}, 32'(rsp_fault), 32'(!d[1]));
    chk(rsp_nonsec == (d[1] & d[3]), {tag, " nonsec"}, 32'(rsp_nonsec), 32'(d[1] & d[3]));
    chk((walks - w0) == (exp_walk ? 1 : 0), {tag, " walk count"}, 32'(walks - w0), exp_walk ? 1 : 0);
    if (exp_walk) begin
      chk(last_addr == tbl_base + {va[31:12], 2'b00}, "R2 descriptor address",
          last_addr, tbl_base + {va[31:12], 2'b00});
      chk(stalls == 0, "R2 ready low during walk", 32'(stalls), 0);
    end else begin
      chk(lat == 0, "R5 hit latency", 32'(lat), 0);
    end
  endtask

  task automatic t_reset_state();
    chk(req_ready == 1'b1, "R1 req_ready", 32'(req_ready), 1);
    chk(rsp_valid == 1'b0, "R1 rsp_valid", 32'(rsp_valid), 0);
    chk(mem_req_valid == 1'b0, "R1 mem_req_valid", 32'(mem_req_valid), 0);
  endtask

  task automatic t_miss_then_hit();
    xl(32'h1234_5ABC, 1, "R3");
    xl(32'h1234_5001, 0, "R5 R9");
    xl(32'h0000_1FFF, 1, "R3 nonsec");
  endtask

  task automatic t_faults();
    xl(32'hF001_2345, 1, "R4 zero");
    xl(32'hF001_2000, 1, "R6 refetch");
    xl(32'hE777_7010, 1, "R4 bit1 clear");
  endtask

  task automatic t_stray();
    @(negedge clk);
    stray_v = 1'b1;
    @(negedge clk);
    stray_v = 1'b0;
    chk(rsp_valid == 1'b0, "R8 stray ignored", 32'(rsp_valid), 0);
    xl(32'h0222_2333, 1, "R8 after stray");
  endtask

  task automatic t_held_request();
    gnt_delay = 3;
    xl(32'h0333_3444, 1, "R8 delayed grant");
    gnt_delay = 0;
    chk(drops == 0, "R8 request held", 32'(drops), 0);
  endtask

  task automatic t_round_robin();
    do_reset();
    for (int i = 0; i < 9; i++) xl({20'h00100 + 20'(i), 12'h040}, 1, "R7 fill");
    xl({20'h00101, 12'h7F0}, 0, "R7 survivor hits");
    xl({20'h00108, 12'h004}, 0, "R7 newest hits");
    xl({20'h00100, 12'h010}, 1, "R7 oldest evicted");
  endtask

  initial begin
    #(CLK_T * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    t_reset_state();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_state();
    t_miss_then_hit();
    t_faults();
    t_stray();
    t_held_request();
    t_round_robin();
    $display("Result: errors=%0d of %0d checks", fails, checks);
    $finish;
  end
endmodule